// File: doc/BRIEF.md
# Paged Program Counter with Table Branch

This block holds the instruction address and the table-lookup registers of a small 4-bit controller that fetches 16-bit instruction words. The 12-bit address is a single page bit stacked above an 11-bit counter. The block can step the counter, load an absolute target that also sets the page bit, or branch into a 256-word table. That table branch keeps the upper four address bits and takes its low byte from a 4-bit table register joined with the 4-bit accumulator. The block also serves the constant-return lookup: the low byte of a fetched ROM word is split between the table register (upper nibble) and the accumulator (lower nibble).

Decoding, ROM and the return stack sit outside. The decoder presents one-hot command strobes. The block takes them only on the last clock of each four-clock instruction cycle, which it marks with its own cycle-phase counter. Returns from the stack arrive as absolute jumps.

Top module: `paged_pc_table`

## Requirements
- R1: While reset is asserted (rst_n low), pc, tbr and acc are all zero and the cycle phase restarts at its first clock.
- R2: An instruction cycle is four clocks long. cyc_last is high on the fourth clock only, and pc, tbr and acc change only on a clock edge where cyc_last is high. Strobes presented on any other clock have no effect.
- R3: inc_stb adds one to pc[10:0], wrapping from 0x7FF to 0x000, and leaves pc[11] unchanged. For example, 0x7FF steps to 0x000 and 0xFFF steps to 0x800.
- R4: jmp_stb loads all 12 bits of jmp_target into pc, including the page bit pc[11].
- R5: tjmp_stb loads pc with {pc[11:8], tbr, acc}, using the values held before the edge: bits 11..8 are kept, bits 7..4 come from tbr and bits 3..0 come from acc.
- R6: If several PC commands are active together, jmp_stb wins over tjmp_stb, and tjmp_stb wins over inc_stb.
- R7: const_ld_stb loads rom_word[7:4] into tbr and rom_word[3:0] into acc. Bits 15..8 of rom_word are ignored.
- R8: tbr_wr loads tbr_wdata into tbr and acc_wr loads acc_wdata into acc. A const_ld_stb in the same cycle overrides both writes.
- R9: With no PC command on a cycle-last clock, pc holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_stb | input | 1 | Step the counter |
| jmp_stb | input | 1 | Absolute jump to jmp_target |
| tjmp_stb | input | 1 | Table branch to {pc[11:8], tbr, acc} |
| const_ld_stb | input | 1 | Split rom_word[7:0] into tbr and acc |
| tbr_wr | input | 1 | Write tbr from tbr_wdata |
| acc_wr | input | 1 | Write acc from acc_wdata |
| jmp_target | input | 12 | Absolute target, bit 11 is the page bit |
| rom_word | input | 16 | Fetched ROM word for constant return |
| tbr_wdata | input | 4 | Data for a tbr write |
| acc_wdata | input | 4 | Data for an acc write |
| pc | output | 12 | Program counter |
| tbr | output | 4 | Table branch register |
| acc | output | 4 | Accumulator |
| cyc_last | output | 1 | High on the last clock of an instruction cycle |

## Verification
The counter is stepped across both ends of the 11-bit field: at 0x7FF it must wrap to 0x000, and at 0xFFF it must wrap to 0x800. A wrong carry into the page bit gives a different result in each case. Table branches are taken from both pages with tbr and acc loaded by direct writes and by constant returns. This separates a lost upper nibble, swapped nibbles and stale register values. Strobe combinations test the jump, table and increment priority and the constant-return override of direct writes. Strobes raised off the cycle boundary must leave every output untouched.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_TJMP = 2'd2,
    SRC_JMP  = 2'd3
  } pc_src_e;

  typedef enum logic [1:0] {
    NIB_HOLD  = 2'd0,
    NIB_WRITE = 2'd1,
    NIB_ROM   = 2'd2
  } nib_src_e;
endpackage

// File: rtl/ppt_phase.sv
module ppt_phase #(
  parameter int CYC_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic cyc_last
);
  localparam int PH_W = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_END = PH_W'(CYC_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (phase_q == PH_END) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign cyc_last = (phase_q == PH_END);
endmodule

// File: rtl/ppt_arbiter.sv
module ppt_arbiter
  import ppt_pkg::*;
(
  input  logic     cyc_last,
  input  logic     inc_stb,
  input  logic     jmp_stb,
  input  logic     tjmp_stb,
  input  logic     const_ld_stb,
  input  logic     tbr_wr,
  input  logic     acc_wr,
  output pc_src_e  pc_src,
  output nib_src_e tbr_src,
  output nib_src_e acc_src,
  output logic     sel_jmp,
  output logic     sel_tjmp,
  output logic     sel_inc,
  output logic     sel_const
);
  always_comb begin
    sel_jmp   = cyc_last && jmp_stb;
    sel_tjmp  = cyc_last && tjmp_stb && !jmp_stb;
    sel_inc   = cyc_last && inc_stb && !jmp_stb && !tjmp_stb;
    sel_const = cyc_last && const_ld_stb;

    if (sel_jmp)       pc_src = SRC_JMP;
    else if (sel_tjmp) pc_src = SRC_TJMP;
    else if (sel_inc)  pc_src = SRC_INC;
    else               pc_src = SRC_HOLD;

    if (sel_const)               tbr_src = NIB_ROM;
    else if (cyc_last && tbr_wr) tbr_src = NIB_WRITE;
    else                         tbr_src = NIB_HOLD;

    if (sel_const)               acc_src = NIB_ROM;
    else if (cyc_last && acc_wr) acc_src = NIB_WRITE;
    else                         acc_src = NIB_HOLD;
  end
endmodule

// File: rtl/ppt_pc_reg.sv
module ppt_pc_reg
  import ppt_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pc_src_e          pc_src,
  input  logic [PC_W-1:0]  jmp_target,
  input  logic [NIB_W-1:0] tbr,
  input  logic [NIB_W-1:0] acc,
  output logic [PC_W-1:0]  pc
);
  localparam int CNT_W = PC_W - 1;
  localparam int OFS_W = 2 * NIB_W;
  localparam int HI_W  = PC_W - OFS_W;

  function automatic logic [PC_W-1:0] step_addr(input logic [PC_W-1:0] a);
    logic [CNT_W-1:0] low;
    low = a[CNT_W-1:0] + 1'b1;
    return {a[PC_W-1], low};
  endfunction

  function automatic logic [PC_W-1:0] table_addr(input logic [PC_W-1:0] a,
                                                 input logic [NIB_W-1:0] t,
                                                 input logic [NIB_W-1:0] x);
    return {a[PC_W-1 -: HI_W], t, x};
  endfunction

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    case (pc_src)
      SRC_INC:  pc_d = step_addr(pc_q);
      SRC_TJMP: pc_d = table_addr(pc_q, tbr, acc);
      SRC_JMP:  pc_d = jmp_target;
      default:  pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/ppt_table_regs.sv
module ppt_table_regs
  import ppt_pkg::*;
#(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nib_src_e          tbr_src,
  input  nib_src_e          acc_src,
  input  logic [WORD_W-1:0] rom_word,
  input  logic [NIB_W-1:0]  tbr_wdata,
  input  logic [NIB_W-1:0]  acc_wdata,
  output logic [NIB_W-1:0]  tbr,
  output logic [NIB_W-1:0]  acc
);
  localparam int NREG = 2;

  logic [NIB_W-1:0] rom_nib [NREG];
  logic [NIB_W-1:0] wr_nib  [NREG];
  nib_src_e         src     [NREG];
  logic [NIB_W-1:0] q       [NREG];

  assign rom_nib[0] = rom_word[2*NIB_W-1 -: NIB_W];
  assign rom_nib[1] = rom_word[NIB_W-1:0];
  assign wr_nib[0]  = tbr_wdata;
  assign wr_nib[1]  = acc_wdata;
  assign src[0]     = tbr_src;
  assign src[1]     = acc_src;

  for (genvar g = 0; g < NREG; g++) begin : g_nib
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else begin
        case (src[g])
          NIB_ROM:   q[g] <= rom_nib[g];
          NIB_WRITE: q[g] <= wr_nib[g];
          default:   q[g] <= q[g];
        endcase
      end
    end
  end

  assign tbr = q[0];
  assign acc = q[1];
endmodule

// File: rtl/paged_pc_table.sv
module paged_pc_table
  import ppt_pkg::*;
#(
  parameter int PC_W     = 12,
  parameter int NIB_W    = 4,
  parameter int WORD_W   = 16,
  parameter int CYC_CLKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_stb,
  input  logic              jmp_stb,
  input  logic              tjmp_stb,
  input  logic              const_ld_stb,
  input  logic              tbr_wr,
  input  logic              acc_wr,
  input  logic [PC_W-1:0]   jmp_target,
  input  logic [WORD_W-1:0] rom_word,
  input  logic [NIB_W-1:0]  tbr_wdata,
  input  logic [NIB_W-1:0]  acc_wdata,
  output logic [PC_W-1:0]   pc,
  output logic [NIB_W-1:0]  tbr,
  output logic [NIB_W-1:0]  acc,
  output logic              cyc_last
);
  pc_src_e  pc_src;
  nib_src_e tbr_src, acc_src;
  logic     sel_jmp, sel_tjmp, sel_inc, sel_const;

  ppt_phase #(.CYC_CLKS(CYC_CLKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .cyc_last(cyc_last)
  );

  ppt_arbiter u_arb (
    .cyc_last(cyc_last), .inc_stb(inc_stb), .jmp_stb(jmp_stb),
    .tjmp_stb(tjmp_stb), .const_ld_stb(const_ld_stb),
    .tbr_wr(tbr_wr), .acc_wr(acc_wr),
    .pc_src(pc_src), .tbr_src(tbr_src), .acc_src(acc_src),
    .sel_jmp(sel_jmp), .sel_tjmp(sel_tjmp), .sel_inc(sel_inc),
    .sel_const(sel_const)
  );

  ppt_pc_reg #(.PC_W(PC_W), .NIB_W(NIB_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .pc_src(pc_src), .jmp_target(jmp_target),
    .tbr(tbr), .acc(acc), .pc(pc)
  );

  ppt_table_regs #(.NIB_W(NIB_W), .WORD_W(WORD_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .tbr_src(tbr_src), .acc_src(acc_src),
    .rom_word(rom_word), .tbr_wdata(tbr_wdata), .acc_wdata(acc_wdata),
    .tbr(tbr), .acc(acc)
  );
endmodule

// File: rtl/paged_pc_table_chk.sv
module paged_pc_table_chk #(
  parameter int PC_W   = 12,
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inc_stb,
  input logic              jmp_stb,
  input logic              tjmp_stb,
  input logic              const_ld_stb,
  input logic              tbr_wr,
  input logic              acc_wr,
  input logic [PC_W-1:0]   jmp_target,
  input logic [WORD_W-1:0] rom_word,
  input logic [NIB_W-1:0]  tbr_wdata,
  input logic [NIB_W-1:0]  acc_wdata,
  input logic [PC_W-1:0]   pc,
  input logic [NIB_W-1:0]  tbr,
  input logic [NIB_W-1:0]  acc,
  input logic              cyc_last,
  input logic              sel_jmp,
  input logic              sel_tjmp,
  input logic              sel_inc,
  input logic              sel_const
);
  localparam int CNT_W = PC_W - 1;
  localparam int OFS_W = 2 * NIB_W;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (pc == '0 && tbr == '0 && acc == '0) || !rst_n);

  a_r2_midcycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_last |=> $stable(pc) && $stable(tbr) && $stable(acc));

  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last |=> !cyc_last);

  a_r3_inc_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    sel_inc |=> pc[PC_W-1] == $past(pc[PC_W-1]) &&
                pc[CNT_W-1:0] == CNT_W'($past(pc[CNT_W-1:0]) + 1'b1));

  a_r4_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    sel_jmp |=> pc == $past(jmp_target));

  a_r5_table_target: assert property (@(posedge clk) disable iff (!rst_n)
    sel_tjmp |=> pc[PC_W-1:OFS_W] == $past(pc[PC_W-1:OFS_W]) &&
                 pc[OFS_W-1:0] == {$past(tbr), $past(acc)});

  a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_jmp, sel_tjmp, sel_inc}));

  a_r6_jump_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last && jmp_stb |-> sel_jmp && !sel_tjmp && !sel_inc);

  a_r7_const_split: assert property (@(posedge clk) disable iff (!rst_n)
    sel_const |=> tbr == $past(rom_word[OFS_W-1:NIB_W]) &&
                  acc == $past(rom_word[NIB_W-1:0]));

  a_r8_tbr_write: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last && tbr_wr && !const_ld_stb |=> tbr == $past(tbr_wdata));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_last && !inc_stb && !jmp_stb && !tjmp_stb |=> $stable(pc));
endmodule

bind paged_pc_table paged_pc_table_chk #(
  .PC_W(PC_W), .NIB_W(NIB_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .jmp_stb(jmp_stb),
  .tjmp_stb(tjmp_stb), .const_ld_stb(const_ld_stb), .tbr_wr(tbr_wr),
  .acc_wr(acc_wr), .jmp_target(jmp_target), .rom_word(rom_word),
  .tbr_wdata(tbr_wdata), .acc_wdata(acc_wdata), .pc(pc), .tbr(tbr),
  .acc(acc), .cyc_last(cyc_last), .sel_jmp(sel_jmp), .sel_tjmp(sel_tjmp),
  .sel_inc(sel_inc), .sel_const(sel_const)
);

// File: tb/tb_paged_pc_table.sv
module tb_paged_pc_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inc_stb = 0, jmp_stb = 0, tjmp_stb = 0, const_ld_stb = 0;
  logic        tbr_wr = 0, acc_wr = 0;
  logic [11:0] jmp_target = '0;
  logic [15:0] rom_word = '0;
  logic [3:0]  tbr_wdata = '0, acc_wdata = '0;
  logic [11:0] pc;
  logic [3:0]  tbr, acc;
  logic        cyc_last;

  int n_vec = 0;
  int n_bad = 0;

  logic [19:0] exp_q[$];
  string       tag_q[$];
  logic [11:0] m_pc = '0;
  logic [3:0]  m_tbr = '0, m_acc = '0;

  always #5 clk = ~clk;

  paged_pc_table dut (
    .clk(clk), .rst_n(rst_n), .inc_stb(inc_stb), .jmp_stb(jmp_stb),
    .tjmp_stb(tjmp_stb), .const_ld_stb(const_ld_stb), .tbr_wr(tbr_wr),
    .acc_wr(acc_wr), .jmp_target(jmp_target), .rom_word(rom_word),
    .tbr_wdata(tbr_wdata), .acc_wdata(acc_wdata), .pc(pc), .tbr(tbr),
    .acc(acc), .cyc_last(cyc_last)
  );

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got pc=%h tbr=%h acc=%h, expected pc=%h tbr=%h acc=%h",
               tag, act[19:8], act[7:4], act[3:0], exp[19:8], exp[7:4], exp[3:0]);
    end
  endtask

  // Drives one instruction cycle and queues the model's expected state.
  task automatic issue(input string tag, input bit i_inc, input bit i_jmp,
                       input bit i_tjmp, input bit i_const, input bit i_tw,
                       input bit i_aw, input logic [11:0] jt,
                       input logic [15:0] rw, input logic [3:0] td,
                       input logic [3:0] ad);
    logic [11:0] npc;
    logic [3:0]  nt, na;
    do @(negedge clk); while (!cyc_last);
    inc_stb = i_inc; jmp_stb = i_jmp; tjmp_stb = i_tjmp; const_ld_stb = i_const;
    tbr_wr = i_tw; acc_wr = i_aw; jmp_target = jt; rom_word = rw;
    tbr_wdata = td; acc_wdata = ad;
    npc = m_pc;
    if (i_jmp)       npc = jt;
    else if (i_tjmp) npc = (m_pc & 12'hF00) | (12'(m_tbr) << 4) | 12'(m_acc);
    else if (i_inc)  npc = (m_pc & 12'h800) | ((m_pc + 12'd1) & 12'h7FF);
    nt = m_tbr; na = m_acc;
    if (i_const) begin
      nt = rw[7:4]; na = rw[3:0];
    end else begin
      if (i_tw) nt = td;
      if (i_aw) na = ad;
    end
    m_pc = npc; m_tbr = nt; m_acc = na;
    exp_q.push_back({npc, nt, na});
    tag_q.push_back(tag);
    @(negedge clk);
    inc_stb = 0; jmp_stb = 0; tjmp_stb = 0; const_ld_stb = 0; tbr_wr = 0; acc_wr = 0;
  endtask

  // Monitor: compares one queued item after each cycle-last edge.
  initial begin
    bit was_last;
    was_last = 0;
    forever begin
      @(negedge clk);
      if (rst_n && was_last && exp_q.size() > 0)
        check(tag_q.pop_front(), {pc, tbr, acc}, exp_q.pop_front());
      was_last = rst_n && cyc_last;
    end
  end

  initial begin
    int wd;
    wd = 0;
    while (wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    check("R1 reset state", {pc, tbr, acc}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 state after release", {pc, tbr, acc}, 20'h0);

    // R2: cycle-last spacing
    do @(negedge clk); while (!cyc_last);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cyc_last);
    check("R2 cycle length", 20'(gap), 20'd4);

    // R3: plain stepping
    issue("R3 step", 1,0,0,0,0,0, '0, '0, '0, '0);
    issue("R3 step", 1,0,0,0,0,0, '0, '0, '0, '0);
    // R4 and R3 wrap in low page
    issue("R4 jump low page", 0,1,0,0,0,0, 12'h7FE, '0, '0, '0);
    issue("R3 step", 1,0,0,0,0,0, '0, '0, '0, '0);
    issue("R3 wrap 7FF", 1,0,0,0,0,0, '0, '0, '0, '0);
    // R4 page bit set, R3 wrap in high page
    issue("R4 jump high page", 0,1,0,0,0,0, 12'hFFE, '0, '0, '0);
    issue("R3 step", 1,0,0,0,0,0, '0, '0, '0, '0);
    issue("R3 wrap FFF", 1,0,0,0,0,0, '0, '0, '0, '0);
    // R8 direct writes, R5 table from high page
    issue("R8 writes", 0,0,0,0,1,1, '0, '0, 4'hA, 4'h5);
    issue("R5 table high page", 0,0,1,0,0,0, '0, '0, '0, '0);
    issue("R4 jump", 0,1,0,0,0,0, 12'h3C0, '0, '0, '0);
    issue("R5 table low page", 0,0,1,0,0,0, '0, '0, '0, '0);
    // R7 constant split, upper byte ignored
    issue("R7 const split", 0,0,0,1,0,0, '0, 16'hBEEF, '0, '0);
    issue("R5 table after const", 0,0,1,0,0,0, '0, '0, '0, '0);
    issue("R7 const split", 0,0,0,1,0,0, '0, 16'h12C3, '0, '0);
    // R6 priority
    issue("R6 jump over all", 1,1,1,0,0,0, 12'h456, '0, '0, '0);
    issue("R6 table over step", 1,0,1,0,0,0, '0, '0, '0, '0);
    // R8 const overrides writes
    issue("R8 const over writes", 0,0,0,1,1,1, '0, 16'h0077, 4'h1, 4'h2);
    issue("R8 acc only", 0,0,0,0,0,1, '0, '0, 4'h9, 4'hD);
    // R9 idle hold
    issue("R9 idle hold", 0,0,0,0,0,0, 12'hABC, 16'hFFFF, 4'hF, 4'hF);

    // R2: strobes off the boundary are ignored
    do @(negedge clk); while (!cyc_last);
    @(negedge clk);
    inc_stb = 1; jmp_stb = 1; tjmp_stb = 1; const_ld_stb = 1; tbr_wr = 1; acc_wr = 1;
    jmp_target = 12'h999; rom_word = 16'h5555; tbr_wdata = 4'h3; acc_wdata = 4'h3;
    @(negedge clk);
    inc_stb = 0; jmp_stb = 0; tjmp_stb = 0; const_ld_stb = 0; tbr_wr = 0; acc_wr = 0;
    check("R2 midcycle strobes ignored", {pc, tbr, acc}, {m_pc, m_tbr, m_acc});
    issue("R2 hold across cycle", 0,0,0,0,0,0, '0, '0, '0, '0);

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule